// File: doc/BRIEF.md
# Command Buffer Pointer Controller

This block keeps the address pointers and the status word for an engine that fetches rendering commands from memory. Software writes a start address and an end address. The block lets a new start address wait while the current list is still being consumed: the start is held as pending, and it only becomes the current fetch pointer when the next end address arrives. Every end write raises a one-cycle kick, which tells the fetcher to process commands from the current pointer up to the end pointer.

The status word holds three control flags. Software changes them through paired clear and set request bits, and the clear request wins when both are given. The status word also holds three busy flags, which the fetcher raises. Four cycle counters sit alongside them. A status write can zero any counter. For the tmem, pipe and command counters, the same write also drops the matching busy flag. Each counter clear is also sent out as a pulse for logic outside the block.

Top module: `cmdbuf_ptr_ctrl`

## Requirements
- R1: Start and end writes keep data bits 23:3. The pointers read back with bits 2:0 and all bits above 23 at zero.
- R2: A start write loads the start pointer only when no start is pending. It leaves the start pointer unchanged when one is pending. Either way, status bit 10 (start pending) is 1 afterwards.
- R3: An end write always loads the end pointer. If a start is pending, the same write copies the start pointer into the current pointer and clears status bit 10. If no start is pending, the current pointer is left unchanged.
- R4: `kick` is high for exactly the one cycle that follows each end write, and at no other time.
- R5: Status write bits come in clear/set pairs. Bits 0/1 drive status bit 0 (bus-to-local-memory DMA select). Bits 2/3 drive status bit 1 (freeze). Bits 4/5 drive status bit 2 (flush). When both bits of a pair are 1, the flag clears. When neither is 1, the flag holds.
- R6: `busy_set[0]`, `busy_set[1]` and `busy_set[2]` set status bits 4 (tmem busy), 5 (pipe busy) and 6 (command busy). These bits stay set until a status write clears them, and that clear wins over a set in the same cycle.
- R7: The clock counter advances every cycle. Each busy counter advances in every cycle its busy bit was set. Status write bits 6, 7 and 8 zero the tmem, pipe and command counter and drop the matching busy bit. Bit 9 zeroes only the clock counter.
- R8: `ctr_clr[i]` pulses in the cycle after a status write that has bit 6+i set (index 0 tmem, 1 pipe, 2 command, 3 clock).
- R9: Register selects are 0 start, 1 end, 2 current, 3 status, 4 clock counter, 5 command counter, 6 pipe counter and 7 tmem counter. Writes to selects 2 and 4 to 7 change nothing. Status bits 3, 7, 8 and 9 read as 0.
- R10: Reset clears every pointer, every counter, every status bit and every output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 32 | Read data, combinational from register state |
| busy_set | input | 3 | Fetcher busy flags: tmem, pipe, command |
| kick | output | 1 | One-cycle pulse after each end write |
| ctr_clr | output | 4 | Counter clear pulses: tmem, pipe, command, clock |

## Verification
The assertions assume that at most one register write arrives per cycle, and the single write port guarantees this. They also assume that `busy_set` may change in any cycle, including a cycle that carries a clearing status write. The stimulus holds every input steady from just before one rising edge until after it. It covers directed cases such as both bits of a pair at once, clear against set in the same cycle, and a start write during a pending start. It then issues a long run of random writes, selects and busy pulses over the full register map.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
   typedef enum logic [2:0] {
      SEL_START = 3'd0,
      SEL_END   = 3'd1,
      SEL_CUR   = 3'd2,
      SEL_STAT  = 3'd3,
      SEL_CLK   = 3'd4,
      SEL_CMDC  = 3'd5,
      SEL_PIPEC = 3'd6,
      SEL_TMEMC = 3'd7
   } cbp_sel_e;

   localparam int N_PAIRS   = 3;
   localparam int N_BUSY    = 3;
   localparam int N_CTR     = 4;
   localparam int STAT_W    = 11;
   localparam int BIT_BUSY0 = 4;
   localparam int BIT_PEND  = 10;
   localparam int WB_CLR0   = 6;
endpackage

// File: rtl/cbp_ptr_regs.sv
module cbp_ptr_regs #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 24,
   parameter int ALIGN  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_we,
   input  logic              end_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] start_q,
   output logic [ADDR_W-1:0] end_q,
   output logic [ADDR_W-1:0] cur_q,
   output logic              pend_q
);
   localparam int KEEP_W = ADDR_W - ALIGN;

   logic [ADDR_W-1:0] aligned;

   generate
      if (ALIGN > 0) begin : g_align
         assign aligned = {wdata[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
      end else begin : g_noalign
         assign aligned = wdata[ADDR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         end_q   <= '0;
         cur_q   <= '0;
         pend_q  <= 1'b0;
      end else begin
         if (start_we) begin
            if (!pend_q) start_q <= aligned;
            pend_q <= 1'b1;
         end
         if (end_we) begin
            end_q <= aligned;
            if (pend_q) begin
               cur_q  <= start_q;
               pend_q <= 1'b0;
            end
         end
      end
   end

   if (KEEP_W < 1) begin : g_bad_align
      $error("cbp_ptr_regs: ALIGN must be below ADDR_W");
   end
endmodule

// File: rtl/cbp_status_reg.sv
module cbp_status_reg
   import cbp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stat_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [N_BUSY-1:0] busy_set,
   output logic [N_PAIRS-1:0] ctl_q,
   output logic [N_BUSY-1:0]  busy_q
);
   genvar gi;
   generate
      for (gi = 0; gi < N_PAIRS; gi++) begin : g_pair
         logic clr_req, set_req;
         assign clr_req = stat_we && wdata[2*gi];
         assign set_req = stat_we && wdata[2*gi+1];
         always_ff @(posedge clk) begin
            if (!rst_n)       ctl_q[gi] <= 1'b0;
            else if (clr_req) ctl_q[gi] <= 1'b0;
            else if (set_req) ctl_q[gi] <= 1'b1;
         end
      end
      for (gi = 0; gi < N_BUSY; gi++) begin : g_busy
         logic clr_req;
         assign clr_req = stat_we && wdata[WB_CLR0+gi];
         always_ff @(posedge clk) begin
            if (!rst_n)            busy_q[gi] <= 1'b0;
            else if (clr_req)      busy_q[gi] <= 1'b0;
            else if (busy_set[gi]) busy_q[gi] <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cbp_counters.sv
module cbp_counters
   import cbp_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_CTR-1:0]            clr,
   input  logic [N_CTR-1:0]            adv,
   output logic [N_CTR-1:0][CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   genvar gi;
   generate
      for (gi = 0; gi < N_CTR; gi++) begin : g_ctr
         always_ff @(posedge clk) begin
            if (!rst_n)       cnt_q[gi] <= '0;
            else if (clr[gi]) cnt_q[gi] <= '0;
            else if (adv[gi]) cnt_q[gi] <= cnt_q[gi] + ONE;
         end
      end
   endgenerate
endmodule

// File: rtl/cmdbuf_ptr_ctrl.sv
module cmdbuf_ptr_ctrl
   import cbp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 24,
   parameter int ALIGN  = 3,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic [2:0]        busy_set,
   output logic              kick,
   output logic [3:0]        ctr_clr
);
   logic start_we, end_we, stat_we;
   logic [ADDR_W-1:0] start_q, end_q, cur_q;
   logic pend_q;
   logic [N_PAIRS-1:0] ctl_q;
   logic [N_BUSY-1:0]  busy_q;
   logic [N_CTR-1:0]   ctr_clr_now, ctr_adv;
   logic [N_CTR-1:0][CNT_W-1:0] cnt_q;
   logic [STAT_W-1:0] stat_w;

   assign start_we = wr_en && (wr_sel == SEL_START);
   assign end_we   = wr_en && (wr_sel == SEL_END);
   assign stat_we  = wr_en && (wr_sel == SEL_STAT);

   cbp_ptr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_ptr (
      .clk(clk), .rst_n(rst_n), .start_we(start_we), .end_we(end_we),
      .wdata(wr_data), .start_q(start_q), .end_q(end_q), .cur_q(cur_q),
      .pend_q(pend_q));

   cbp_status_reg #(.DATA_W(DATA_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .stat_we(stat_we), .wdata(wr_data),
      .busy_set(busy_set), .ctl_q(ctl_q), .busy_q(busy_q));

   genvar gi;
   generate
      for (gi = 0; gi < N_CTR; gi++) begin : g_clr
         assign ctr_clr_now[gi] = stat_we && wr_data[WB_CLR0+gi];
      end
      for (gi = 0; gi < N_BUSY; gi++) begin : g_adv
         assign ctr_adv[gi] = busy_q[gi];
      end
   endgenerate
   assign ctr_adv[N_CTR-1] = 1'b1;

   cbp_counters #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(ctr_clr_now), .adv(ctr_adv),
      .cnt_q(cnt_q));

   always_comb begin
      stat_w = '0;
      stat_w[N_PAIRS-1:0] = ctl_q;
      stat_w[BIT_BUSY0 +: N_BUSY] = busy_q;
      stat_w[BIT_PEND] = pend_q;
   end

   always_comb begin
      unique case (cbp_sel_e'(rd_sel))
         SEL_START: rd_data = DATA_W'(start_q);
         SEL_END:   rd_data = DATA_W'(end_q);
         SEL_CUR:   rd_data = DATA_W'(cur_q);
         SEL_STAT:  rd_data = DATA_W'(stat_w);
         SEL_CLK:   rd_data = DATA_W'(cnt_q[3]);
         SEL_CMDC:  rd_data = DATA_W'(cnt_q[2]);
         SEL_PIPEC: rd_data = DATA_W'(cnt_q[1]);
         SEL_TMEMC: rd_data = DATA_W'(cnt_q[0]);
         default:   rd_data = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kick    <= 1'b0;
         ctr_clr <= '0;
      end else begin
         kick    <= end_we;
         ctr_clr <= ctr_clr_now;
      end
   end

   if (DATA_W < ADDR_W || DATA_W < CNT_W || DATA_W < WB_CLR0 + N_CTR) begin : g_bad_w
      $error("cmdbuf_ptr_ctrl: DATA_W too narrow");
   end
endmodule

// File: rtl/cbp_checker.sv
module cbp_checker #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [2:0]        wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              kick,
   input logic [3:0]        ctr_clr,
   input logic [ADDR_W-1:0] start_q,
   input logic [ADDR_W-1:0] cur_q,
   input logic              pend_q,
   input logic [10:0]       stat_w,
   input logic [3:0][CNT_W-1:0] cnt_q
);
   logic st_w, en_w, sw_w;
   assign st_w = wr_en && wr_sel == 3'd0;
   assign en_w = wr_en && wr_sel == 3'd1;
   assign sw_w = wr_en && wr_sel == 3'd3;

   assert_ptr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_q[2:0] == 3'b0 && cur_q[2:0] == 3'b0);

   assert_start_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_w && pend_q) |=> (start_q == $past(start_q) && pend_q));

   assert_end_promote_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_w && pend_q) |=> (cur_q == $past(start_q) && !pend_q));

   assert_kick_follows_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en_w |=> kick);

   assert_kick_only_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_w && !$past(en_w)) |=> !kick);

   assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_w && wr_data[2] && wr_data[3]) |=> !stat_w[1]);

   assert_cmd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_w && wr_data[8]) |=> (cnt_q[2] == '0 && !stat_w[6] && ctr_clr[2]));

   assert_clr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_w |=> ctr_clr == 4'b0);

   assert_fixed_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_w[9:7] == 3'b0 && !stat_w[3]);
endmodule

bind cmdbuf_ptr_ctrl cbp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .kick(kick), .ctr_clr(ctr_clr), .start_q(start_q), .cur_q(cur_q),
   .pend_q(pend_q), .stat_w(stat_w), .cnt_q(cnt_q));

// File: tb/sim_cmdbuf_ptr_ctrl.sv
module sim_cmdbuf_ptr_ctrl;
   localparam int CLK_PERIOD = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic [2:0]  busy_set = '0;
   logic        kick;
   logic [3:0]  ctr_clr;

   int tests = 0;
   int fails = 0;

   // reference state
   logic [31:0] m_start, m_end, m_cur, m_clk, m_cmd, m_pipe, m_tmem;
   logic        m_pend, m_kick;
   logic [2:0]  m_ctl, m_busy;
   logic [3:0]  m_clr;

   cmdbuf_ptr_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .busy_set(busy_set), .kick(kick), .ctr_clr(ctr_clr));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_start = 0; m_end = 0; m_cur = 0; m_pend = 0; m_kick = 0;
      m_clk = 0; m_cmd = 0; m_pipe = 0; m_tmem = 0;
      m_ctl = 0; m_busy = 0; m_clr = 0;
   endtask

   function automatic logic [31:0] m_read(input int s);
      logic [31:0] st;
      st = 0;
      st[2:0] = m_ctl;
      st[6:4] = m_busy;
      st[10]  = m_pend;
      case (s)
         0: return m_start;
         1: return m_end;
         2: return m_cur;
         3: return st;
         4: return m_clk;
         5: return m_cmd;
         6: return m_pipe;
         default: return m_tmem;
      endcase
   endfunction

   // R1 R2 R3 R5 R6 R7: reference update for one rising edge
   task automatic model_edge();
      logic [31:0] a;
      logic [2:0]  nb;
      logic [3:0]  c;
      a = wr_data & 32'h00FF_FFF8;
      c = (wr_en && wr_sel == 3) ? wr_data[9:6] : 4'b0;
      m_kick = wr_en && wr_sel == 1;
      m_clk  = c[3] ? 0 : ((m_clk + 1) & 32'h00FF_FFFF);
      m_tmem = c[0] ? 0 : (m_busy[0] ? ((m_tmem + 1) & 32'h00FF_FFFF) : m_tmem);
      m_pipe = c[1] ? 0 : (m_busy[1] ? ((m_pipe + 1) & 32'h00FF_FFFF) : m_pipe);
      m_cmd  = c[2] ? 0 : (m_busy[2] ? ((m_cmd + 1) & 32'h00FF_FFFF) : m_cmd);
      for (int i = 0; i < 3; i++) nb[i] = c[i] ? 1'b0 : (m_busy[i] | busy_set[i]);
      m_busy = nb;
      m_clr = c;
      if (wr_en && wr_sel == 3) begin
         for (int i = 0; i < 3; i++) begin
            if (wr_data[2*i]) m_ctl[i] = 1'b0;
            else if (wr_data[2*i+1]) m_ctl[i] = 1'b1;
         end
      end
      if (wr_en && wr_sel == 0) begin
         if (!m_pend) m_start = a;
         m_pend = 1'b1;
      end
      if (wr_en && wr_sel == 1) begin
         m_end = a;
         if (m_pend) begin m_cur = m_start; m_pend = 1'b0; end
      end
   endtask

   task automatic compare_all();
      check("R4 kick", {31'b0, kick}, {31'b0, m_kick});
      check("R8 ctr_clr", {28'b0, ctr_clr}, {28'b0, m_clr});
      for (int s = 0; s < 8; s++) begin
         rd_sel = 3'(s);
         #1;
         case (s)
            0, 1, 2: check("R1/R2/R3 pointer read", rd_data, m_read(s));
            3:       check("R5/R6/R9 status read", rd_data, m_read(s));
            default: check("R7 counter read", rd_data, m_read(s));
         endcase
      end
   endtask

   task automatic step(input logic we, input logic [2:0] sel,
                       input logic [31:0] d, input logic [2:0] bs);
      wr_en = we; wr_sel = sel; wr_data = d; busy_set = bs;
      @(posedge clk);
      if (rst_n) model_edge(); else model_reset();
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      model_reset();
      // R10: reset state, with busy and writes presented during reset
      step(1, 0, 32'h1234_5678, 3'b111);
      step(1, 3, 32'hFFFF_FFFF, 3'b111);
      rst_n = 1'b1;
      // R1 R2: start latched, masked
      step(1, 0, 32'hFFFF_FFFF, 0);
      // R2: second start while pending is ignored
      step(1, 0, 32'h0000_1238, 0);
      // R3 R4: end promotes pending start
      step(1, 1, 32'h0000_4447, 0);
      step(0, 0, 0, 0);
      // R3: end with nothing pending leaves current
      step(1, 1, 32'h0000_8000, 0);
      // R2 R3: new start then end
      step(1, 0, 32'h0012_3450, 0);
      step(1, 1, 32'h0012_4000, 0);
      // R5: sets, then both, then none
      step(1, 3, 32'h0000_002A, 0);
      step(1, 3, 32'h0000_000C, 0);
      step(1, 3, 32'h0000_0000, 0);
      step(1, 3, 32'h0000_0015, 0);
      // R6 R7: busy flags and counters
      step(0, 0, 0, 3'b111);
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0);
      // R6 R7 R8: clear cmd while set is asserted
      step(1, 3, 32'h0000_0100, 3'b100);
      step(0, 0, 0, 0);
      // R7 R8: clear clock only, then tmem and pipe
      step(1, 3, 32'h0000_0200, 0);
      step(1, 3, 32'h0000_00C0, 0);
      // R9: writes to read-only selects
      for (int s = 4; s < 8; s++) step(1, 3'(s), 32'hFFFF_FFFF, 0);
      step(1, 2, 32'hFFFF_FFFF, 0);
      // random traffic
      for (int i = 0; i < 600; i++)
         step(($urandom % 3) != 0, 3'($urandom), $urandom, 3'($urandom % 8 == 0 ? $urandom : 0));
      // R10: reset mid-run
      rst_n = 1'b0;
      step(0, 0, 0, 0);
      rst_n = 1'b1;
      step(0, 0, 0, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule